// File: doc/BRIEF.md
# Sector Write-Protection Guard with Password Lock

This block decides, for each sector of a flash-style memory, whether a program or erase aimed at that sector may go ahead. Each sector carries three protection bits. The first is a persistent protect bit that survives a hardware reset. The second is a dynamic protect bit that a hardware reset returns to its default. The third is a volatile mask bit that can hide the persistent bit for a while.

A global freeze flag guards the persistent bits and the mask bits. It can be released only by a hardware reset or a power-up. Once the one-time password mode has been entered, the only way to release it is a rate-limited unlock command that carries a 64-bit value equal to the stored password.

A command decoder upstream sends the block one-cycle commands: an opcode, a sector index and a 64-bit data word. The memory controller sends one-cycle protection queries and gets a registered grant or deny back. Two resets are kept apart. `por_n` models a power-up and clears everything. `hw_rst_n` models the hardware reset pin and keeps the persistent state.

Top module: `sector_guard`

## Requirements
- R1: A query (`req_valid`) for sector s gives `req_done`=1 one cycle later, with `req_grant`=1 only if sector s is unprotected. A sector is protected when its dynamic bit is 1, or when its persistent bit is 1 and its mask bit is 1.
- R2: Opcode 13 (status) gives `stat_valid`=1 one cycle later. In the same cycle the status outputs carry sector s's dynamic, persistent and mask bits and the freeze flag.
- R3: Opcode 1 sets the persistent bit of sector s, and opcode 2 clears all persistent bits. Both have no effect while the freeze flag is 1.
- R4: Opcode 5 clears the mask bit of sector s, which hides its persistent protection, and opcode 6 sets it again. Both have no effect while the freeze flag is 1. Opcode 3 sets and opcode 4 clears the dynamic bit at any time.
- R5: Opcode 7 sets the freeze flag. Outside password mode, no command clears the flag: the soft-reset opcode 11 leaves it unchanged, and only `hw_rst_n` low or `por_n` low clears it.
- R6: While `hw_rst_n` is low, at a clock edge the dynamic bits return to DYN_INIT and the mask bits return to 1. The persistent bits, the password and the password-mode flag are kept.
- R7: `por_n` low returns every bit to its default: persistent bits 0, dynamic bits DYN_INIT, mask bits 1, freeze flag 0, password all ones and password mode off.
- R8: Opcode 8 replaces the password with the AND of the password and the data, so no bit can go from 0 to 1. Opcode 9 gives `pw_valid` one cycle later, with the password on `pw_rdata`.
- R9: Opcode 10 enters password mode, which no command can leave. In password mode, opcode 8 is ignored and opcode 9 returns HIDDEN_VAL (default 0).
- R10: In password mode, opcode 11 and a hardware reset both set the freeze flag.
- R11: In password mode, an accepted unlock (opcode 12) whose data equals the password clears the freeze flag UNLOCK_CYC cycles after the unlock. A data word that does not match never clears it.
- R12: An unlock that arrives within UNLOCK_CYC cycles of the last accepted unlock is rejected and does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| hw_rst_n | input | 1 | Hardware reset, synchronous, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_sector | input | SW | Target sector of the command |
| cmd_data | input | 64 | Password or unlock data |
| req_valid | input | 1 | Protection query strobe |
| req_sector | input | SW | Sector queried |
| req_done | output | 1 | Query answered |
| req_grant | output | 1 | 1 when the queried sector may be changed |
| stat_valid | output | 1 | Status word valid |
| stat_dyn | output | 1 | Dynamic bit of the sector |
| stat_persist | output | 1 | Persistent bit of the sector |
| stat_mask | output | 1 | Mask bit of the sector |
| stat_frozen | output | 1 | Freeze flag |
| pw_valid | output | 1 | Password read valid |
| pw_rdata | output | 64 | Password or HIDDEN_VAL |

## Verification
A random mix of bit set and clear commands, freezes, hardware resets, queries and status reads is checked against a bench model. This stream separates the three-bit protection rule from simpler rules, because the mask only matters when the persistent bit is set and the dynamic bit is clear. Directed sequences then take the password path in order: programming, mode entry and hiding, and forced freeze. The sequence also sends a wrong unlock followed at once by a correct one, which tells the rate limit apart from a plain compare. A correct unlock is read back both before and after its delay, to show the release is timed. A final power-up pulse separates what is persistent from what is volatile.

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int NSEC = 16,
  parameter int UNLOCK_CYC = 100,
  parameter bit DYN_INIT = 1'b0,
  parameter logic [63:0] HIDDEN_VAL = 64'h0,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int CW = $clog2(UNLOCK_CYC + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hw_rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [SW-1:0] cmd_sector,
  input  logic [63:0]   cmd_data,
  input  logic          req_valid,
  input  logic [SW-1:0] req_sector,
  output logic          req_done,
  output logic          req_grant,
  output logic          stat_valid,
  output logic          stat_dyn,
  output logic          stat_persist,
  output logic          stat_mask,
  output logic          stat_frozen,
  output logic          pw_valid,
  output logic [63:0]   pw_rdata
);
  localparam logic [3:0] OP_PSET = 4'd1, OP_PCLR = 4'd2, OP_DSET = 4'd3, OP_DCLR = 4'd4,
                         OP_MCLR = 4'd5, OP_MSET = 4'd6, OP_FREEZE = 4'd7, OP_PWPROG = 4'd8,
                         OP_PWREAD = 4'd9, OP_PWMODE = 4'd10, OP_SOFTRST = 4'd11,
                         OP_UNLOCK = 4'd12, OP_STATUS = 4'd13;

  logic [NSEC-1:0] persist, dyn, mask, prot;
  logic [63:0]     pw;
  logic            pw_mode, frozen, pend;
  logic [CW-1:0]   gap;
  logic            sec_ok, rq_ok, cmd_go;

  assign prot   = dyn | (persist & mask);
  assign sec_ok = 32'(cmd_sector) < NSEC;
  assign rq_ok  = 32'(req_sector) < NSEC;
  assign cmd_go = cmd_valid && hw_rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      persist <= '0;
      pw      <= '1;
      pw_mode <= 1'b0;
    end else if (cmd_go) begin
      case (cmd_op)
        OP_PSET:   if (!frozen && sec_ok) persist[cmd_sector] <= 1'b1;
        OP_PCLR:   if (!frozen) persist <= '0;
        OP_PWPROG: if (!pw_mode) pw <= pw & cmd_data;
        OP_PWMODE: pw_mode <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dyn <= {NSEC{DYN_INIT}};
      mask <= '1;
      frozen <= 1'b0;
      pend <= 1'b0;
      gap <= '0;
      req_done <= 1'b0; req_grant <= 1'b0;
      stat_valid <= 1'b0; stat_dyn <= 1'b0; stat_persist <= 1'b0;
      stat_mask <= 1'b0; stat_frozen <= 1'b0;
      pw_valid <= 1'b0; pw_rdata <= '0;
    end else if (!hw_rst_n) begin
      dyn <= {NSEC{DYN_INIT}};
      mask <= '1;
      frozen <= pw_mode;
      pend <= 1'b0;
      gap <= '0;
      req_done <= 1'b0; req_grant <= 1'b0;
      stat_valid <= 1'b0; pw_valid <= 1'b0;
    end else begin
      req_done   <= req_valid;
      req_grant  <= req_valid && rq_ok && !prot[req_sector];
      stat_valid <= 1'b0;
      pw_valid   <= 1'b0;
      if (gap != '0) begin
        gap <= gap - 1'b1;
        if (gap == CW'(1) && pend) begin
          frozen <= 1'b0;
          pend   <= 1'b0;
        end
      end
      if (cmd_valid) begin
        case (cmd_op)
          OP_DSET:    if (sec_ok) dyn[cmd_sector] <= 1'b1;
          OP_DCLR:    if (sec_ok) dyn[cmd_sector] <= 1'b0;
          OP_MCLR:    if (!frozen && sec_ok) mask[cmd_sector] <= 1'b0;
          OP_MSET:    if (!frozen && sec_ok) mask[cmd_sector] <= 1'b1;
          OP_FREEZE:  frozen <= 1'b1;
          OP_SOFTRST: if (pw_mode) frozen <= 1'b1;
          OP_UNLOCK:
            if (pw_mode && gap == '0) begin
              gap  <= CW'(UNLOCK_CYC);
              pend <= (cmd_data == pw);
            end
          OP_PWREAD: begin
            pw_valid <= 1'b1;
            pw_rdata <= pw_mode ? HIDDEN_VAL : pw;
          end
          OP_STATUS: begin
            stat_valid   <= 1'b1;
            stat_dyn     <= sec_ok && dyn[cmd_sector];
            stat_persist <= sec_ok && persist[cmd_sector];
            stat_mask    <= sec_ok && mask[cmd_sector];
            stat_frozen  <= frozen;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
    req_done |-> $past(req_valid)); // R1
  AST_PERSIST_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    $past(frozen) |-> $stable(persist)); // R3
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    ($past(frozen) && $past(hw_rst_n)) |-> $stable(mask)); // R4
  AST_PW_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (pw & ~$past(pw)) == 64'h0); // R8
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    $past(pw_mode) |-> pw_mode); // R9
  AST_UNLOCK_MATCH: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(frozen) && pw_mode) |-> $past(pend)); // R11
endmodule

// File: tb/sim_sector_guard.sv
module sim_sector_guard;
  localparam int NSEC = 16;
  localparam int UC = 24;
  localparam int SW = $clog2(NSEC);

  logic clk = 1'b0, por_n = 1'b0, hw_rst_n = 1'b1;
  logic cmd_valid = 1'b0, req_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [SW-1:0] cmd_sector = '0, req_sector = '0;
  logic [63:0] cmd_data = '0;
  logic req_done, req_grant, stat_valid, stat_dyn, stat_persist, stat_mask, stat_frozen, pw_valid;
  logic [63:0] pw_rdata;

  int checks = 0, errors = 0;
  logic [NSEC-1:0] m_per, m_dyn, m_msk;
  logic m_frz, m_mode;
  logic [63:0] m_pw;

  always #10 clk = ~clk;

  sector_guard #(.NSEC(NSEC), .UNLOCK_CYC(UC)) u0 (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_data(cmd_data), .req_valid(req_valid), .req_sector(req_sector),
    .req_done(req_done), .req_grant(req_grant), .stat_valid(stat_valid), .stat_dyn(stat_dyn),
    .stat_persist(stat_persist), .stat_mask(stat_mask), .stat_frozen(stat_frozen),
    .pw_valid(pw_valid), .pw_rdata(pw_rdata));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_grant(int s);
    return !(m_dyn[s] || (m_per[s] && m_msk[s]));
  endfunction

  task automatic model_defaults();
    m_per = '0; m_dyn = '0; m_msk = '1; m_frz = 0; m_mode = 0; m_pw = '1;
  endtask

  task automatic do_cmd(logic [3:0] op, int s, logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_sector = SW'(s); cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    case (op)
      4'd1: if (!m_frz) m_per[s] = 1;
      4'd2: if (!m_frz) m_per = '0;
      4'd3: m_dyn[s] = 1;
      4'd4: m_dyn[s] = 0;
      4'd5: if (!m_frz) m_msk[s] = 0;
      4'd6: if (!m_frz) m_msk[s] = 1;
      4'd7: m_frz = 1;
      4'd8: if (!m_mode) m_pw = m_pw & d;
      4'd10: m_mode = 1;
      4'd11: if (m_mode) m_frz = 1;
      default: ;
    endcase
  endtask

  task automatic check_status(string req, int s);
    do_cmd(4'd13, s, 0);
    check(req, {stat_valid, stat_dyn, stat_persist, stat_mask, stat_frozen},
          {1'b1, m_dyn[s], m_per[s], m_msk[s], m_frz});
  endtask

  task automatic check_req(string req, int s);
    @(negedge clk);
    req_valid = 1; req_sector = SW'(s);
    @(negedge clk);
    req_valid = 0;
    check(req, {req_done, req_grant}, {1'b1, exp_grant(s)});
  endtask

  task automatic check_pw(string req, logic [63:0] exp);
    do_cmd(4'd9, 0, 0);
    check(req, {63'h0, pw_valid}, 64'h1);
    check(req, pw_rdata, exp);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    hw_rst_n = 0;
    @(negedge clk);
    hw_rst_n = 1;
    m_dyn = '0; m_msk = '1; m_frz = m_mode;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    model_defaults();
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    check("R7 reset outputs", {62'h0, req_done, stat_valid}, 64'h0);
    check_status("R7 reset status", 0);
    check_req("R1 reset grant", NSEC - 1);

    do_cmd(4'd1, 2, 0);
    check_req("R1 persist protects", 2);
    do_cmd(4'd5, 2, 0);
    check_req("R4 mask unprotects", 2);
    do_cmd(4'd3, 2, 0);
    check_req("R1 dynamic overrides mask", 2);
    check_status("R2 status word", 2);
    do_cmd(4'd7, 0, 0);
    do_cmd(4'd1, 3, 0);
    check_status("R3 frozen persist set ignored", 3);
    do_cmd(4'd6, 2, 0);
    check_status("R4 frozen mask change ignored", 2);
    do_cmd(4'd11, 0, 0);
    check_status("R5 soft reset keeps freeze", 0);
    hw_reset();
    check_status("R6 hw reset keeps persist", 2);
    check_req("R6 hw reset restores mask", 2);

    for (int i = 0; i < 600; i++) begin
      int r, s;
      r = $urandom % 16;
      s = $urandom % NSEC;
      case (r)
        0, 1: do_cmd(4'd1, s, 0);
        2: if ($urandom % 4 == 0) do_cmd(4'd2, s, 0);
        3, 4: do_cmd(4'd3, s, 0);
        5: do_cmd(4'd4, s, 0);
        6: do_cmd(4'd5, s, 0);
        7: do_cmd(4'd6, s, 0);
        8: if ($urandom % 3 == 0) do_cmd(4'd7, s, 0);
        9: hw_reset();
        10, 11, 12: check_req("R1 random query", s);
        default: check_status("R2 random status", s);
      endcase
    end

    hw_reset();
    check_pw("R8 password default", 64'hFFFF_FFFF_FFFF_FFFF);
    do_cmd(4'd8, 0, 64'hF0F0_1234_FFFF_00FF);
    do_cmd(4'd8, 0, 64'hFFFF_FFFF_0F0F_FFFF);
    check_pw("R8 password AND", 64'hF0F0_1234_0F0F_00FF);
    do_cmd(4'd10, 0, 0);
    check_pw("R9 password hidden", 64'h0);
    do_cmd(4'd8, 0, 64'h0);
    do_cmd(4'd11, 0, 0);
    check_status("R10 soft reset freezes", 0);
    do_cmd(4'd12, 0, 64'h1);
    do_cmd(4'd12, 0, m_pw);
    wait_cyc(UC + 3);
    check_status("R12 early unlock rejected", 0);
    do_cmd(4'd12, 0, m_pw);
    check_status("R11 freeze held during delay", 0);
    wait_cyc(UC - 6);
    check_status("R11 freeze held near end of delay", 0);
    wait_cyc(8);
    m_frz = 0;
    check_status("R11 unlock releases freeze", 0);
    do_cmd(4'd1, 5, 0);
    check_status("R3 persist set after unlock", 5);
    hw_reset();
    check_status("R10 hw reset freezes in password mode", 5);

    @(negedge clk);
    por_n = 0;
    @(negedge clk);
    por_n = 1;
    model_defaults();
    check_status("R7 power-up clears persist", 5);
    check_pw("R7 power-up restores password", 64'hFFFF_FFFF_FFFF_FFFF);
    do_cmd(4'd11, 0, 0);
    check_status("R5 soft reset no freeze outside mode", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule